// File: doc/BRIEF.md
# Line Remote Error Count Accumulator

This block takes the M1 overhead byte of each received STS-3/STM-1 frame, interprets it as the number of line errors the far end reports back, and sums those reports into a running counter. A performance-monitoring strobe closes each interval. On that strobe the running total moves into an 18-bit holding register, which is the only output, and the running counter starts again from zero.

Three static configuration inputs shape the interpretation. The first clears bit 7 of the byte before it is read. The second selects counting of reported errors or counting of frames that report any error. The third decides whether the running counter stops at its top value or wraps. Computing the parity that produces the far end's report, and any software access path, belong to neighbouring blocks.

Top module: `lrei_acc`

## Requirements
- R1: After synchronous reset, `hold_cnt` reads 0 and the running count is 0, so a strobe given before any frame loads 0.
- R2: In error-count mode (`cfg_blk_mode` = 0), a frame whose byte value v is in 0..24 adds v to the running count.
- R3: A byte value of 25 or above, after the optional bit 7 clearing, adds nothing in either mode.
- R4: With `cfg_drop_msb` = 1, bit 7 of the byte is forced to 0 before the 0..24 range test (0x85 counts as 5). With it at 0, the full eight bits are tested (0x85 counts as nothing).
- R5: In frame-count mode (`cfg_blk_mode` = 1), each frame with a value in 1..24 adds exactly 1, and a frame with value 0 or 25 or above adds 0.
- R6: On a clock edge with `pm_tick` high, the running count is copied into `hold_cnt`, which changes on that same edge, and the running count is cleared.
- R7: A frame presented in the same cycle as `pm_tick` is not part of the value loaded into `hold_cnt`. Its contribution becomes the first term of the new interval.
- R8: `hold_cnt` changes only on an edge with `pm_tick` high.
- R9: With `cfg_sat` = 1, a sum beyond 2^18-1 leaves the running count at 2^18-1 until the next strobe.
- R10: With `cfg_sat` = 0, the running count wraps modulo 2^18.
- R11: While `frm_vld` is low, `m1_byte` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_vld | input | 1 | One-cycle strobe: `m1_byte` holds this frame's M1 byte |
| m1_byte | input | 8 | Received M1 byte |
| pm_tick | input | 1 | Performance-monitoring interval strobe |
| cfg_drop_msb | input | 1 | 1: clear bit 7 before interpretation |
| cfg_blk_mode | input | 1 | 0: add error count; 1: add one per erroring frame |
| cfg_sat | input | 1 | 1: saturate at maximum; 0: wrap |
| hold_cnt | output | 18 | Count of the last completed interval |

## Verification
On every cycle, the assertions check the following: the reset state, the stability of the holding register between strobes, the exact copy of the running count on a strobe, the clearing and re-seeding of the counter on a strobe, that idle cycles leave it untouched, the at-most-one step in frame-count mode, the ignoring of out-of-range bytes, and that saturation holds. Only the directed scenarios show the actual interval totals. These include the bit 7 clearing cases, the overlap of a frame with a strobe, and the two outcomes when more than ten thousand maximal reports push the 18-bit counter past its limit, where the result is 262143 when saturating and 8 when wrapping.

// File: rtl/lrei_pkg.sv
package lrei_pkg;

    localparam int unsigned LREI_BYTE_W  = 8;
    localparam int unsigned LREI_MAX_ERR = 24;
    localparam int unsigned LREI_CNT_W   = 18;
    localparam int unsigned LREI_INC_W   = $clog2(LREI_MAX_ERR + 1);

    typedef enum logic {
        MODE_ERRS   = 1'b0,
        MODE_FRAMES = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_SAT  = 1'b1
    } ovf_mode_e;

    // Decoded report of one frame
    typedef struct packed {
        logic                  hit;   // value within 1..MAX_ERR
        logic [LREI_INC_W-1:0] errs;  // value if in range, else 0
    } rei_word_t;

endpackage

// File: rtl/lrei_decode.sv
module lrei_decode
    import lrei_pkg::*;
#(
    parameter int unsigned BYTE_W  = LREI_BYTE_W,
    parameter int unsigned MAX_ERR = LREI_MAX_ERR,
    parameter int unsigned INC_W   = LREI_INC_W
) (
    input  logic [BYTE_W-1:0] m1,
    input  logic              drop_msb,
    input  logic              frm_vld,
    input  cnt_mode_e         mode,
    output rei_word_t         word,
    output logic [INC_W-1:0]  inc
);

    logic [BYTE_W-1:0] val;
    logic              in_range;

    always_comb begin
        val = m1;
        if (drop_msb) begin
            val[BYTE_W-1] = 1'b0;
        end
        in_range  = (val <= BYTE_W'(MAX_ERR));
        word.hit  = in_range && (val != '0);
        word.errs = in_range ? LREI_INC_W'(val) : '0;
    end

    always_comb begin
        inc = '0;
        if (frm_vld) begin
            unique case (mode)
                MODE_ERRS:   inc = INC_W'(word.errs);
                MODE_FRAMES: inc = INC_W'(word.hit);
                default:     inc = '0;
            endcase
        end
    end

endmodule

// File: rtl/lrei_running.sv
module lrei_running
    import lrei_pkg::*;
#(
    parameter int unsigned CNT_W = LREI_CNT_W,
    parameter int unsigned INC_W = LREI_INC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [INC_W-1:0] inc,
    input  ovf_mode_e        ovf,
    output logic [CNT_W-1:0] acc
);

    localparam int unsigned PAD_W = CNT_W - INC_W;

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] inc_ext;
    logic [CNT_W-1:0] acc_nxt;

    always_comb begin
        inc_ext = {{PAD_W{1'b0}}, inc};
        sum     = {1'b0, acc} + {1'b0, inc_ext};
        if (clear) begin
            acc_nxt = inc_ext;
        end else if (sum[CNT_W] && (ovf == OVF_SAT)) begin
            acc_nxt = '1;
        end else begin
            acc_nxt = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            acc <= acc_nxt;
        end
    end

endmodule

// File: rtl/lrei_hold.sv
module lrei_hold
    import lrei_pkg::*;
#(
    parameter int unsigned CNT_W = LREI_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/lrei_acc.sv
module lrei_acc
    import lrei_pkg::*;
#(
    parameter int unsigned BYTE_W  = LREI_BYTE_W,
    parameter int unsigned MAX_ERR = LREI_MAX_ERR,
    parameter int unsigned CNT_W   = LREI_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_vld,
    input  logic [BYTE_W-1:0] m1_byte,
    input  logic              pm_tick,
    input  logic              cfg_drop_msb,
    input  logic              cfg_blk_mode,
    input  logic              cfg_sat,
    output logic [CNT_W-1:0]  hold_cnt
);

    localparam int unsigned INC_W = $clog2(MAX_ERR + 1);

    rei_word_t        word;
    logic [INC_W-1:0] inc;
    logic [CNT_W-1:0] acc_q;

    lrei_decode #(
        .BYTE_W (BYTE_W),
        .MAX_ERR(MAX_ERR),
        .INC_W  (INC_W)
    ) u_dec (
        .m1      (m1_byte),
        .drop_msb(cfg_drop_msb),
        .frm_vld (frm_vld),
        .mode    (cnt_mode_e'(cfg_blk_mode)),
        .word    (word),
        .inc     (inc)
    );

    lrei_running #(
        .CNT_W(CNT_W),
        .INC_W(INC_W)
    ) u_run (
        .clk  (clk),
        .rst  (rst),
        .clear(pm_tick),
        .inc  (inc),
        .ovf  (ovf_mode_e'(cfg_sat)),
        .acc  (acc_q)
    );

    lrei_hold #(
        .CNT_W(CNT_W)
    ) u_hold (
        .clk (clk),
        .rst (rst),
        .load(pm_tick),
        .din (acc_q),
        .dout(hold_cnt)
    );

endmodule

// File: rtl/lrei_chk.sv
module lrei_chk #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned MAX_ERR = 24,
    parameter int unsigned CNT_W   = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_vld,
    input logic [BYTE_W-1:0] m1_byte,
    input logic              pm_tick,
    input logic              cfg_drop_msb,
    input logic              cfg_blk_mode,
    input logic              cfg_sat,
    input logic [CNT_W-1:0]  hold_cnt,
    input logic [CNT_W-1:0]  acc_q
);

    localparam logic [CNT_W-1:0] TOP = '1;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (hold_cnt == '0) && (acc_q == '0));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !pm_tick |=> $stable(hold_cnt));

    a_r6_hold_copy: assert property (@(posedge clk) disable iff (rst)
        pm_tick |=> hold_cnt == $past(acc_q));

    a_r7_fresh_interval: assert property (@(posedge clk) disable iff (rst)
        (pm_tick && !frm_vld) |=> acc_q == '0);

    a_r11_idle_keep: assert property (@(posedge clk) disable iff (rst)
        (!pm_tick && !frm_vld) |=> $stable(acc_q));

    a_r3_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !pm_tick && !cfg_drop_msb && (m1_byte > BYTE_W'(MAX_ERR)))
        |=> $stable(acc_q));

    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !pm_tick && cfg_blk_mode && (acc_q != TOP))
        |=> (acc_q == $past(acc_q)) || (acc_q == $past(acc_q) + 1'b1));

    a_r9_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_sat && !pm_tick && (acc_q == TOP)) |=> acc_q == TOP);

endmodule

bind lrei_acc lrei_chk #(
    .BYTE_W (BYTE_W),
    .MAX_ERR(MAX_ERR),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frm_vld     (frm_vld),
    .m1_byte     (m1_byte),
    .pm_tick     (pm_tick),
    .cfg_drop_msb(cfg_drop_msb),
    .cfg_blk_mode(cfg_blk_mode),
    .cfg_sat     (cfg_sat),
    .hold_cnt    (hold_cnt),
    .acc_q       (acc_q)
);

// File: tb/sim_lrei_acc.sv
module sim_lrei_acc;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_vld;
    logic [7:0]  m1_byte;
    logic        pm_tick;
    logic        cfg_drop_msb;
    logic        cfg_blk_mode;
    logic        cfg_sat;
    logic [17:0] hold_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrei_acc u0 (
        .clk         (clk),
        .rst         (rst),
        .frm_vld     (frm_vld),
        .m1_byte     (m1_byte),
        .pm_tick     (pm_tick),
        .cfg_drop_msb(cfg_drop_msb),
        .cfg_blk_mode(cfg_blk_mode),
        .cfg_sat     (cfg_sat),
        .hold_cnt    (hold_cnt)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: hold_cnt actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] b);
        frm_vld = 1'b1;
        m1_byte = b;
        @(negedge clk);
        frm_vld = 1'b0;
        m1_byte = 8'h00;
    endtask

    task automatic strobe();
        pm_tick = 1'b1;
        @(negedge clk);
        pm_tick = 1'b0;
    endtask

    task automatic drain(input string req, input logic [17:0] exp);
        strobe();
        check(req, hold_cnt, exp);
    endtask

    task automatic t_reset();
        check("R1 reset value", hold_cnt, 18'd0);
        drain("R1 first strobe", 18'd0);
    endtask

    task automatic t_err_mode();
        cfg_blk_mode = 1'b0;
        frame(8'd5); frame(8'd24); frame(8'd0); frame(8'd1);
        check("R8 hold unchanged without strobe", hold_cnt, 18'd0);
        drain("R2 error sum", 18'd30);
        check("R8 hold after strobe", hold_cnt, 18'd30);
    endtask

    task automatic t_invalid();
        frame(8'd25); frame(8'd200); frame(8'd255); frame(8'd3);
        drain("R3 values above 24", 18'd3);
    endtask

    task automatic t_drop_msb();
        cfg_drop_msb = 1'b1;
        frame(8'h85); frame(8'h99); frame(8'h98);
        drain("R4 bit7 cleared", 18'd29);
        cfg_drop_msb = 1'b0;
        frame(8'h85); frame(8'h99); frame(8'h98);
        drain("R4 bit7 kept", 18'd0);
    endtask

    task automatic t_block();
        cfg_blk_mode = 1'b1;
        frame(8'd7); frame(8'd0); frame(8'd24); frame(8'd30); frame(8'd1);
        drain("R5 frame count", 18'd3);
        cfg_blk_mode = 1'b0;
    endtask

    task automatic t_idle();
        m1_byte = 8'd24;
        repeat (5) @(negedge clk);
        m1_byte = 8'd0;
        drain("R11 no frame strobe", 18'd0);
    endtask

    task automatic t_overlap();
        frame(8'd4);
        frm_vld = 1'b1; m1_byte = 8'd6; pm_tick = 1'b1;
        @(negedge clk);
        frm_vld = 1'b0; m1_byte = 8'd0; pm_tick = 1'b0;
        check("R6 R7 old interval only", hold_cnt, 18'd4);
        drain("R7 frame moved to new interval", 18'd6);
    endtask

    task automatic flood(input int n);
        frm_vld = 1'b1;
        m1_byte = 8'd24;
        repeat (n) @(negedge clk);
        frm_vld = 1'b0;
        m1_byte = 8'd0;
    endtask

    task automatic t_saturate();
        cfg_sat = 1'b1;
        flood(10923);
        drain("R9 saturation", 18'h3FFFF);
        drain("R6 cleared after strobe", 18'd0);
    endtask

    task automatic t_wrap();
        cfg_sat = 1'b0;
        flood(10923);
        drain("R10 wrap", 18'd8);
    endtask

    initial begin
        rst = 1'b1; frm_vld = 1'b0; m1_byte = 8'd0; pm_tick = 1'b0;
        cfg_drop_msb = 1'b0; cfg_blk_mode = 1'b0; cfg_sat = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_err_mode();
        t_invalid();
        t_drop_msb();
        t_block();
        t_idle();
        t_overlap();
        t_saturate();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule